// File: doc/BRIEF.md
# Low-Voltage Detect Control Register

This block is an 8-bit status and control register for a supply low-voltage monitor. A comparator outside the block reports a low-supply condition. The block synchronizes that signal and latches it into a sticky flag. Software clears the flag by writing an acknowledge bit. The flag can raise an interrupt request, a reset request, or both. The same byte also holds the bandgap reference enable used by the converter.

The bus port has a single write strobe, write data and a combinational read value. Address decode is done upstream. Two enables are write-once: the detector enable and the reset enable. Both are held by one lock state machine with two states. `LK_OPEN` is the state after reset. The first register write of any value takes it to `LK_SHUT` (transition "first write"), and it stays there until reset. The flag is a second state machine with two states. `FL_IDLE` moves to `FL_SEEN` on a qualified detect event (transition "detect"). `FL_SEEN` returns to `FL_IDLE` on an acknowledge write that arrives without a coincident event (transition "acknowledge"). A detect event wins over an acknowledge in the same cycle.

Top module: `lvd_ctrl_reg`

## Requirements
- R1: The flag (read bit 7) sets on the third rising clock edge after `cmp_low_i` goes high, provided the detector enable (bit 2) is 1 at that edge. It never sets while bit 2 is 0, and once set it stays set until acknowledged.
- R2: Writing a byte with bit 6 = 1 clears the flag on that edge. Read bit 6 is always 0.
- R3: If a qualified detect event and an acknowledge write occur on the same edge, the flag is 1 after that edge.
- R4: `irq_o` is 1 exactly when the flag is 1 and the interrupt enable (bit 5) is 1. With bit 5 = 0 the flag is visible only by reading.
- R5: Bits 4 and 2 take the value of the first write after reset. Any later write leaves them unchanged, whatever the value of that later write.
- R6: `rst_req_o` is 1 exactly when the flag, the reset enable (bit 4) and the detector enable (bit 2) are all 1.
- R7: While `stop_i` = 1 and the stop enable (bit 3) is 0, the flag does not set. With bit 3 = 1, detection continues during stop.
- R8: Bit 1 is reserved. It reads 0 and the value written to it has no effect.
- R9: Bits 5, 3 and 0 are writable at every write. Bit 0 drives `bgap_en_o`.
- R10: After reset the register reads 0x1C and `irq_o`, `rst_req_o` and `bgap_en_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmp_low_i | input | 1 | Asynchronous low-supply comparator output |
| stop_i | input | 1 | High while the chip is in stop mode |
| wr_en_i | input | 1 | Register write strobe, address already decoded |
| wr_data_i | input | 8 | Write data |
| rd_data_o | output | 8 | Current register read value |
| irq_o | output | 1 | Low-voltage interrupt request |
| rst_req_o | output | 1 | Low-voltage reset request |
| bgap_en_o | output | 1 | Bandgap reference buffer enable |

## Verification
The assertions assume that `wr_en_i` and `wr_data_i` are valid and stable at each rising edge. They also assume that `stop_i` is a synchronous level. Only `cmp_low_i` may change at any time.

The bench changes every input on the falling edge, so each value is settled well before the next rising edge. The bench holds the comparator level for at least three cycles whenever it expects the flag to react. Because of this, the synchronizer delay is always covered before a result is checked.

// File: rtl/lvd_pkg.sv
package lvd_pkg;
    localparam int REG_W    = 8;
    localparam int B_FLAG   = 7;
    localparam int B_ACK    = 6;
    localparam int B_IRQEN  = 5;
    localparam int B_RSTEN  = 4;
    localparam int B_STOPEN = 3;
    localparam int B_DETEN  = 2;
    localparam int B_RSVD   = 1;
    localparam int B_BGAP   = 0;

    typedef enum logic {LK_OPEN = 1'b0, LK_SHUT = 1'b1} lock_state_e;
    typedef enum logic {FL_IDLE = 1'b0, FL_SEEN = 1'b1} flag_state_e;
endpackage

// File: rtl/lvd_sync.sv
module lvd_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= d_i;
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= {chain_q[STAGES-2:0], d_i};
            end
        end
    endgenerate

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/lvd_lock_fsm.sv
module lvd_lock_fsm
    import lvd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_i,
    output logic open_o
);
    lock_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LK_OPEN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        open_o  = 1'b0;
        unique case (state_q)
            LK_OPEN: begin
                open_o = 1'b1;
                if (wr_i) state_d = LK_SHUT;
            end
            LK_SHUT: begin
                open_o  = 1'b0;
                state_d = LK_SHUT;
            end
        endcase
    end

    // R5
    lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LK_SHUT) |=> (state_q == LK_SHUT));
endmodule

// File: rtl/lvd_flag_fsm.sv
module lvd_flag_fsm
    import lvd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic ack_i,
    output logic flag_o
);
    flag_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FL_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        flag_o  = 1'b0;
        unique case (state_q)
            FL_IDLE: begin
                flag_o = 1'b0;
                if (set_i) state_d = FL_SEEN;
            end
            FL_SEEN: begin
                flag_o = 1'b1;
                if (ack_i && !set_i) state_d = FL_IDLE;
            end
        endcase
    end

    // R3
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> flag_o);
    // R2
    ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && !set_i) |=> !flag_o);
    // R1
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && !ack_i) |=> flag_o);
endmodule

// File: rtl/lvd_ctrl_reg.sv
module lvd_ctrl_reg
    import lvd_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmp_low_i,
    input  logic             stop_i,
    input  logic             wr_en_i,
    input  logic [REG_W-1:0] wr_data_i,
    output logic [REG_W-1:0] rd_data_o,
    output logic             irq_o,
    output logic             rst_req_o,
    output logic             bgap_en_o
);
    logic low_sync;
    logic once_open;
    logic flag;
    logic set_evt;
    logic ack_evt;
    logic irq_en_q, rst_en_q, stop_en_q, det_en_q, bgap_q;

    lvd_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (cmp_low_i),
        .q_o   (low_sync)
    );

    lvd_lock_fsm u_lock (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_i   (wr_en_i),
        .open_o (once_open)
    );

    always_comb begin
        set_evt = low_sync && det_en_q && (!stop_i || stop_en_q);
        ack_evt = wr_en_i && wr_data_i[B_ACK];
    end

    lvd_flag_fsm u_flag (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (set_evt),
        .ack_i  (ack_evt),
        .flag_o (flag)
    );

    // Freely writable controls
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_en_q  <= 1'b0;
            stop_en_q <= 1'b1;
            bgap_q    <= 1'b0;
        end else if (wr_en_i) begin
            irq_en_q  <= wr_data_i[B_IRQEN];
            stop_en_q <= wr_data_i[B_STOPEN];
            bgap_q    <= wr_data_i[B_BGAP];
        end
    end

    // Write-once controls, gated by the lock state machine
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rst_en_q <= 1'b1;
            det_en_q <= 1'b1;
        end else if (wr_en_i && once_open) begin
            rst_en_q <= wr_data_i[B_RSTEN];
            det_en_q <= wr_data_i[B_DETEN];
        end
    end

    always_comb begin
        rd_data_o           = '0;
        rd_data_o[B_FLAG]   = flag;
        rd_data_o[B_IRQEN]  = irq_en_q;
        rd_data_o[B_RSTEN]  = rst_en_q;
        rd_data_o[B_STOPEN] = stop_en_q;
        rd_data_o[B_DETEN]  = det_en_q;
        rd_data_o[B_BGAP]   = bgap_q;
        irq_o               = flag && irq_en_q;
        rst_req_o           = flag && rst_en_q && det_en_q;
        bgap_en_o           = bgap_q;
    end

    // R5
    once_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!once_open && wr_en_i) |=> (rst_en_q == $past(rst_en_q) && det_en_q == $past(det_en_q)));
    // R7
    stop_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_i && !stop_en_q && !flag) |=> !flag);
    // R1
    det_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!det_en_q && !flag) |=> !flag);
endmodule

// File: tb/lvd_ctrl_reg_tb.sv
module lvd_ctrl_reg_tb;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       cmp_low_i, stop_i, wr_en_i;
    logic [7:0] wr_data_i;
    logic [7:0] rd_data_o;
    logic       irq_o, rst_req_o, bgap_en_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    lvd_ctrl_reg u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmp_low_i (cmp_low_i),
        .stop_i    (stop_i),
        .wr_en_i   (wr_en_i),
        .wr_data_i (wr_data_i),
        .rd_data_o (rd_data_o),
        .irq_o     (irq_o),
        .rst_req_o (rst_req_o),
        .bgap_en_o (bgap_en_o)
    );

    // {req[3:0], wr, wdata[7:0], cmp, stop, exp_rd[7:0], exp_irq, exp_rst}
    localparam int NV = 20;
    localparam logic [24:0] VEC [NV] = '{
        {4'd5, 1'b1, 8'h25, 1'b0, 1'b0, 8'h25, 1'b0, 1'b0}, // R5 first write clears bit4
        {4'd8, 1'b1, 8'h3F, 1'b0, 1'b0, 8'h2D, 1'b0, 1'b0}, // R8 bit1 ignored, R5 bit4 locked, R9 bit3
        {4'd5, 1'b1, 8'h29, 1'b0, 1'b0, 8'h2D, 1'b0, 1'b0}, // R5 bit2 locked
        {4'd1, 1'b0, 8'h00, 1'b1, 1'b0, 8'h2D, 1'b0, 1'b0}, // R1 sync stage 1
        {4'd1, 1'b0, 8'h00, 1'b1, 1'b0, 8'h2D, 1'b0, 1'b0}, // R1 sync stage 2
        {4'd4, 1'b0, 8'h00, 1'b1, 1'b0, 8'hAD, 1'b1, 1'b0}, // R4 irq with flag, R6 rst_en off
        {4'd3, 1'b1, 8'h6D, 1'b0, 1'b0, 8'hAD, 1'b1, 1'b0}, // R3 set beats ack
        {4'd1, 1'b0, 8'h00, 1'b0, 1'b0, 8'hAD, 1'b1, 1'b0}, // R1 flag sticky
        {4'd2, 1'b1, 8'h6D, 1'b0, 1'b0, 8'h2D, 1'b0, 1'b0}, // R2 ack clears, bit6 reads 0
        {4'd9, 1'b1, 8'h0D, 1'b0, 1'b0, 8'h0D, 1'b0, 1'b0}, // R9 irq enable cleared
        {4'd7, 1'b0, 8'h00, 1'b1, 1'b1, 8'h0D, 1'b0, 1'b0}, // R7 stop with stop enable
        {4'd7, 1'b0, 8'h00, 1'b1, 1'b1, 8'h0D, 1'b0, 1'b0},
        {4'd4, 1'b0, 8'h00, 1'b1, 1'b1, 8'h8D, 1'b0, 1'b0}, // R4 polling, no irq; R7 detect in stop
        {4'd1, 1'b0, 8'h00, 1'b0, 1'b0, 8'h8D, 1'b0, 1'b0},
        {4'd1, 1'b0, 8'h00, 1'b0, 1'b0, 8'h8D, 1'b0, 1'b0},
        {4'd2, 1'b1, 8'h45, 1'b0, 1'b0, 8'h05, 1'b0, 1'b0}, // R2 ack, R9 stop enable off
        {4'd7, 1'b0, 8'h00, 1'b1, 1'b1, 8'h05, 1'b0, 1'b0}, // R7 gated in stop
        {4'd7, 1'b0, 8'h00, 1'b1, 1'b1, 8'h05, 1'b0, 1'b0},
        {4'd7, 1'b0, 8'h00, 1'b1, 1'b1, 8'h05, 1'b0, 1'b0},
        {4'd7, 1'b0, 8'h00, 1'b1, 1'b0, 8'h85, 1'b0, 1'b0}  // R7 detects once stop leaves
    };

    task automatic check(input int req, input logic [7:0] erd, input logic eirq,
                         input logic erst, input logic ebg);
        checks++;
        if (rd_data_o !== erd || irq_o !== eirq || rst_req_o !== erst || bgap_en_o !== ebg) begin
            errors++;
            $display("FAIL R%0d: rd=%h irq=%b rst=%b bg=%b expected rd=%h irq=%b rst=%b bg=%b",
                     req, rd_data_o, irq_o, rst_req_o, bgap_en_o, erd, eirq, erst, ebg);
        end
    endtask

    task automatic cycle(input logic wr, input logic [7:0] d, input logic cmp, input logic stp);
        wr_en_i   = wr;
        wr_data_i = d;
        cmp_low_i = cmp;
        stop_i    = stp;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n     = 1'b0;
        wr_en_i   = 1'b0;
        wr_data_i = 8'h00;
        cmp_low_i = 1'b0;
        stop_i    = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        do_reset();
        check(10, 8'h1C, 1'b0, 1'b0, 1'b0); // R10 reset state

        for (int i = 0; i < NV; i++) begin
            logic [24:0] v;
            v = VEC[i];
            cycle(v[20], v[19:12], v[11], v[10]);
            check(int'(v[24:21]), v[9:2], v[1], v[0], v[2]);
        end

        // R6: reset request with default enables, R10 again
        do_reset();
        check(10, 8'h1C, 1'b0, 1'b0, 1'b0);
        cycle(1'b0, 8'h00, 1'b1, 1'b0);
        cycle(1'b0, 8'h00, 1'b1, 1'b0);
        check(1, 8'h1C, 1'b0, 1'b0, 1'b0);  // R1 not yet after two edges
        cycle(1'b0, 8'h00, 1'b1, 1'b0);
        check(6, 8'h9C, 1'b0, 1'b1, 1'b0);  // R6 reset request
        repeat (3) cycle(1'b0, 8'h00, 1'b0, 1'b0);
        check(6, 8'h9C, 1'b0, 1'b1, 1'b0);
        cycle(1'b1, 8'h5C, 1'b0, 1'b0);
        check(2, 8'h1C, 1'b0, 1'b0, 1'b0);  // R2 ack drops request
        cycle(1'b1, 8'h08, 1'b0, 1'b0);
        check(5, 8'h1C, 1'b0, 1'b0, 1'b0);  // R5 later write cannot clear bits 4, 2

        // R5 and R1: first write disables detector, then locked off
        do_reset();
        cycle(1'b1, 8'h00, 1'b0, 1'b0);
        check(5, 8'h00, 1'b0, 1'b0, 1'b0);
        cycle(1'b1, 8'h14, 1'b0, 1'b0);
        check(5, 8'h00, 1'b0, 1'b0, 1'b0);
        repeat (4) cycle(1'b0, 8'h00, 1'b1, 1'b0);
        check(1, 8'h00, 1'b0, 1'b0, 1'b0);  // R1 no set with detector off
        cycle(1'b1, 8'h03, 1'b1, 1'b0);
        check(8, 8'h01, 1'b0, 1'b0, 1'b1);  // R8 bit1 reads 0, R9 bandgap on

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule